// File: doc/BRIEF.md
# Rate-Halving Memory Relay Buffer

This block sits between a fast host-side memory bus and a rank of DRAM devices that run at half the host data rate. Every bus cycle it registers the packed command/address word from the host and presents it to the devices one bus cycle later. Unused upper bits are forced to zero. It also derives the device clock from the bus clock with a one-hot ring divider. It relays full 64-byte lines in both directions, with a separate one-line staging entry for each direction. Each line is 8 beats of 64 bits. Host beats arrive one per bus cycle, and device beats last one device cycle, which is `DIV` bus cycles.

Each entry starts its output before its input is complete. The write entry (host to device) starts issuing device beats once the first host beat is buffered. The read entry (device to host) waits just long enough that its faster output stream can never run ahead of the slower input. A burst that arrives while an entry still holds an undrained line is rejected and reported. It never overwrites the line.

Write state machine:
- States: `WR_IDLE`, `WR_FILL`, `WR_DRAIN`.
- Transitions: idle→fill on the first host beat; fill→drain on the last host beat; drain→idle when the last device beat is issued.

Read state machine:
- States: `RD_IDLE`, `RD_FILL`, `RD_STREAM`.
- Transitions: idle→fill when device beat 0 is captured; fill→stream when device beat `RD_LEAD` is captured (4 by default); stream→idle when the last host beat is issued.

Top module: `rate_halving_relay`

## Requirements
- R1: `dev_cmd` equals `host_cmd` of the previous bus cycle with bits 31:23 forced to 0. The command layout is: bits 2:0 bank, bits 16:3 address, 17 ras_n, 18 cas_n, 19 we_n, 20 cke, 21 odt, 22 cs_n.
- R2: While `rst_n` is low, the following hold, and a reset during a transfer discards the partial line:
  - `dev_cmd` is 32'h004E0000 (cs_n, ras_n, cas_n and we_n high; cke, odt and all other bits low).
  - `dev_clk`, `dev_wr_vld`, `host_rd_vld`, `host_wr_err` and `host_rd_err` are 0.
- R3: `dev_clk` has a period of `DIV` bus cycles. After the n-th bus edge following reset release (n from 0), it is high when (n+1) mod DIV >= DIV/2. With DIV=2 it rises at the first edge and toggles every edge.
- R4: The 8 host write beats reach `dev_wr_data` in order. Each is flagged by `dev_wr_vld` for exactly DIV consecutive bus cycles with no gaps, changing only at edges where `dev_clk` falls. `dev_wr_vld` drops after beat 7.
- R5: Device write beat 0 is issued at the first falling edge of `dev_clk` strictly after the edge that captured host beat 0. This is before the host burst ends.
- R6: Device read beats are captured at the edges where `dev_clk` falls. They appear on `host_rd_data` in order, one per bus cycle, flagged by `host_rd_vld` for 8 consecutive cycles.
- R7: With default parameters, the last host read beat is issued two bus cycles (one device cycle) after the edge that captured the last device beat. `host_rd_vld` is low in the cycle before the first host beat and in the cycle after the last.
- R8: Host write beats that arrive while the write entry holds a complete, undrained line are discarded. `host_wr_err` is high in the cycle after each such beat, and the line being drained reaches the devices unchanged.
- R9: A device beat captured while the read entry holds a complete, undrained line is discarded. `host_rd_err` pulses high for one cycle after the capture edge, and the host stream in progress is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_cmd | input | 32 | Packed command/address word from the host |
| dev_cmd | output | 32 | Relayed command/address word to the devices |
| dev_clk | output | 1 | Divided device clock |
| host_wr_vld | input | 1 | Host write beat valid |
| host_wr_data | input | 64 | Host write beat data |
| host_wr_err | output | 1 | Rejected host write beat (pulse) |
| dev_wr_vld | output | 1 | Device write beat valid |
| dev_wr_data | output | 64 | Device write beat data |
| dev_rd_vld | input | 1 | Device read beat valid |
| dev_rd_data | input | 64 | Device read beat data |
| host_rd_vld | output | 1 | Host read beat valid |
| host_rd_data | output | 64 | Host read beat data |
| host_rd_err | output | 1 | Rejected device read beat (pulse) |

## Verification
A write entry that issues a beat before it has stored it shows up quickly at `dev_wr_data`: within one device cycle the port carries stale data, or the beat is held for the wrong number of bus cycles. A read entry that leaves `RD_FILL` too early repeats or skips a beat on `host_rd_data` near the end of the line. One that leaves too late shifts the whole 8-cycle window by whole cycles, and sampling that window cycle by cycle against the last capture edge exposes it. A corrupted phase of the divider moves the first device write beat by one bus cycle, and the R5 alignment check in both phases catches it.

// File: rtl/rhr_pkg.sv
package rhr_pkg;

    localparam int CMD_W      = 32;
    localparam int CMD_USED   = 23;
    localparam int BA_LSB     = 0;
    localparam int ADDR_LSB   = 3;
    localparam int RAS_N_BIT  = 17;
    localparam int CAS_N_BIT  = 18;
    localparam int WE_N_BIT   = 19;
    localparam int CKE_BIT    = 20;
    localparam int ODT_BIT    = 21;
    localparam int CS_N_BIT   = 22;

    // bits that carry meaning; everything above is driven to zero
    localparam logic [CMD_W-1:0] CMD_MASK =
        {{(CMD_W-CMD_USED){1'b0}}, {CMD_USED{1'b1}}};

    // no-operation word: chip deselected, all strobes inactive
    localparam logic [CMD_W-1:0] CMD_IDLE =
        (CMD_W'(1) << RAS_N_BIT) | (CMD_W'(1) << CAS_N_BIT) |
        (CMD_W'(1) << WE_N_BIT)  | (CMD_W'(1) << CS_N_BIT);

    typedef enum logic [1:0] {
        WR_IDLE  = 2'd0,
        WR_FILL  = 2'd1,
        WR_DRAIN = 2'd2
    } wr_state_e;

    typedef enum logic [1:0] {
        RD_IDLE   = 2'd0,
        RD_FILL   = 2'd1,
        RD_STREAM = 2'd2
    } rd_state_e;

endpackage

// File: rtl/rhr_clkdiv.sv
module rhr_clkdiv #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic dev_clk,
    output logic tick
);
    localparam int HALF = DIV / 2;

    logic [DIV-1:0] ring;
    logic [DIV-1:0] ring_nxt;

    assign ring_nxt = {ring[DIV-2:0], ring[DIV-1]};
    // last slot of the ring: the device clock falls at this edge
    assign tick     = ring[DIV-1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ring    <= DIV'(1);
            dev_clk <= 1'b0;
        end else begin
            ring    <= ring_nxt;
            dev_clk <= |ring_nxt[DIV-1:HALF];
        end
    end

    // R3
    tick_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> dev_clk);

    // R3
    tick_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !dev_clk);

endmodule

// File: rtl/rhr_cmd_relay.sv
module rhr_cmd_relay
    import rhr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CMD_W-1:0] host_cmd,
    output logic [CMD_W-1:0] dev_cmd
);
    logic armed;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dev_cmd <= CMD_IDLE;
            armed   <= 1'b0;
        end else begin
            dev_cmd <= host_cmd & CMD_MASK;
            armed   <= 1'b1;
        end
    end

    // R1
    cmd_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (dev_cmd == ($past(host_cmd) & CMD_MASK)));

endmodule

// File: rtl/rhr_wr_entry.sv
module rhr_wr_entry
    import rhr_pkg::*;
#(
    parameter int BEATS  = 8,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              in_vld,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_err,
    output logic              out_vld,
    output logic [DATA_W-1:0] out_data
);
    localparam int CW = $clog2(BEATS + 1);
    localparam int IW = $clog2(BEATS);

    wr_state_e         state, nxt;
    logic [DATA_W-1:0] line [BEATS];
    logic [CW-1:0]     in_cnt;
    logic [CW-1:0]     out_idx;
    logic              take;
    logic              emit;
    logic              done;

    assign take = in_vld && (state != WR_DRAIN);
    assign emit = tick && (out_idx < in_cnt);
    assign done = (state == WR_DRAIN) && (nxt == WR_IDLE);

    always_comb begin
        nxt = state;
        unique case (state)
            WR_IDLE:  if (in_vld) nxt = WR_FILL;
            WR_FILL:  if (in_vld && in_cnt == CW'(BEATS-1)) nxt = WR_DRAIN;
            WR_DRAIN: if (tick && out_idx == CW'(BEATS-1)) nxt = WR_IDLE;
            default:  nxt = WR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= WR_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < BEATS; i++) line[i] <= '0;
            in_cnt   <= '0;
            out_idx  <= '0;
            out_vld  <= 1'b0;
            out_data <= '0;
            in_err   <= 1'b0;
        end else begin
            in_err <= in_vld && (state == WR_DRAIN);
            if (take) line[in_cnt[IW-1:0]] <= in_data;
            if (tick) begin
                out_vld <= emit;
                if (emit) out_data <= line[out_idx[IW-1:0]];
            end
            if (done) begin
                in_cnt  <= '0;
                out_idx <= '0;
            end else begin
                if (take) in_cnt  <= in_cnt + CW'(1);
                if (emit) out_idx <= out_idx + CW'(1);
            end
        end
    end

    // R4
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(out_vld) && $stable(out_data)));

    // R4
    wr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_idx <= in_cnt) && (in_cnt <= CW'(BEATS)));

    // R8
    wr_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_err |-> ($past(state) == WR_DRAIN));

endmodule

// File: rtl/rhr_rd_entry.sv
module rhr_rd_entry
    import rhr_pkg::*;
#(
    parameter int BEATS  = 8,
    parameter int DATA_W = 64,
    parameter int DIV    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              in_vld,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_err,
    output logic              out_vld,
    output logic [DATA_W-1:0] out_data
);
    localparam int CW      = $clog2(BEATS + 1);
    localparam int IW      = $clog2(BEATS);
    // index of the captured beat that starts the fast stream without underrun
    localparam int RD_LEAD = ((DIV - 1) * (BEATS - 1) + DIV - 1) / DIV;

    rd_state_e         state, nxt;
    logic [DATA_W-1:0] line [BEATS];
    logic [CW-1:0]     in_cnt;
    logic [CW-1:0]     out_idx;
    logic              cap;
    logic              full;
    logic              accept;
    logic              done;

    assign cap    = tick && in_vld;
    assign full   = (in_cnt == CW'(BEATS));
    assign accept = cap && !full;
    assign done   = (state == RD_STREAM) && (nxt == RD_IDLE);

    always_comb begin
        nxt = state;
        unique case (state)
            RD_IDLE:   if (cap) nxt = RD_FILL;
            RD_FILL:   if (cap && in_cnt == CW'(RD_LEAD)) nxt = RD_STREAM;
            RD_STREAM: if (out_idx == CW'(BEATS-1)) nxt = RD_IDLE;
            default:   nxt = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= RD_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < BEATS; i++) line[i] <= '0;
            in_cnt   <= '0;
            out_idx  <= '0;
            out_vld  <= 1'b0;
            out_data <= '0;
            in_err   <= 1'b0;
        end else begin
            in_err  <= cap && full;
            out_vld <= (state == RD_STREAM);
            if (accept) line[in_cnt[IW-1:0]] <= in_data;
            if (state == RD_STREAM) out_data <= line[out_idx[IW-1:0]];
            if (done) begin
                in_cnt  <= '0;
                out_idx <= '0;
            end else begin
                if (accept) in_cnt <= in_cnt + CW'(1);
                if (state == RD_STREAM) out_idx <= out_idx + CW'(1);
            end
        end
    end

    // R7
    rd_underrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RD_STREAM) |-> (out_idx < in_cnt));

    // R9
    rd_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_err |-> ($past(state) == RD_STREAM));

    // R6
    rd_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_cnt <= CW'(BEATS));

endmodule

// File: rtl/rate_halving_relay.sv
module rate_halving_relay
    import rhr_pkg::*;
#(
    parameter int DIV    = 2,
    parameter int BEATS  = 8,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CMD_W-1:0]  host_cmd,
    output logic [CMD_W-1:0]  dev_cmd,
    output logic              dev_clk,
    input  logic              host_wr_vld,
    input  logic [DATA_W-1:0] host_wr_data,
    output logic              host_wr_err,
    output logic              dev_wr_vld,
    output logic [DATA_W-1:0] dev_wr_data,
    input  logic              dev_rd_vld,
    input  logic [DATA_W-1:0] dev_rd_data,
    output logic              host_rd_vld,
    output logic [DATA_W-1:0] host_rd_data,
    output logic              host_rd_err
);
    logic tick;

    rhr_clkdiv #(.DIV(DIV)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .dev_clk (dev_clk),
        .tick    (tick)
    );

    rhr_cmd_relay u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .host_cmd (host_cmd),
        .dev_cmd  (dev_cmd)
    );

    rhr_wr_entry #(.BEATS(BEATS), .DATA_W(DATA_W)) u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .in_vld   (host_wr_vld),
        .in_data  (host_wr_data),
        .in_err   (host_wr_err),
        .out_vld  (dev_wr_vld),
        .out_data (dev_wr_data)
    );

    rhr_rd_entry #(.BEATS(BEATS), .DATA_W(DATA_W), .DIV(DIV)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .in_vld   (dev_rd_vld),
        .in_data  (dev_rd_data),
        .in_err   (host_rd_err),
        .out_vld  (host_rd_vld),
        .out_data (host_rd_data)
    );

endmodule

// File: tb/test_rate_halving_relay.sv
module test_rate_halving_relay;
    localparam int BEATS = 8;
    localparam int DIV   = 2;
    localparam int NS    = 24;
    localparam logic [31:0] IDLE_WORD = 32'h004E0000;

    // {stimulus, expected}
    localparam logic [63:0] CMD_VEC [6] = '{
        {32'hFFFFFFFF, 32'h007FFFFF},
        {32'h12345678, 32'h00345678},
        {32'hFF800000, 32'h00000000},
        {32'h004E0000, 32'h004E0000},
        {32'h00000007, 32'h00000007},
        {32'hA5A5A5A5, 32'h0025A5A5}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] host_cmd = '0;
    logic [31:0] dev_cmd;
    logic        dev_clk;
    logic        host_wr_vld = 1'b0;
    logic [63:0] host_wr_data = '0;
    logic        host_wr_err;
    logic        dev_wr_vld;
    logic [63:0] dev_wr_data;
    logic        dev_rd_vld = 1'b0;
    logic [63:0] dev_rd_data = '0;
    logic        host_rd_vld;
    logic [63:0] host_rd_data;
    logic        host_rd_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic        s_vld [NS];
    logic [63:0] s_dat [NS];
    logic        s_clk [NS];
    logic        s_err [NS];

    always #10 clk = ~clk;

    rate_halving_relay i_rate_halving_relay (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_cmd     (host_cmd),
        .dev_cmd      (dev_cmd),
        .dev_clk      (dev_clk),
        .host_wr_vld  (host_wr_vld),
        .host_wr_data (host_wr_data),
        .host_wr_err  (host_wr_err),
        .dev_wr_vld   (dev_wr_vld),
        .dev_wr_data  (dev_wr_data),
        .dev_rd_vld   (dev_rd_vld),
        .dev_rd_data  (dev_rd_data),
        .host_rd_vld  (host_rd_vld),
        .host_rd_data (host_rd_data),
        .host_rd_err  (host_rd_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] wpat(input int burst, input int k);
        return {16'hC0DE, 16'(burst), 32'(k) * 32'h01010101};
    endfunction

    function automatic logic [63:0] rpat(input int burst, input int k);
        return {16'hBEEF, 16'(burst), 32'(k) * 32'h11111111};
    endfunction

    task automatic run_wr(input int burst, input bit phase, input bit conflict);
        int first;
        int exp_first;
        @(negedge clk);
        while (dev_clk !== phase) @(negedge clk);
        // R5: first dev_clk fall strictly after the capture edge
        exp_first = phase ? 3 : 2;
        fork
            begin
                for (int k = 0; k < BEATS; k++) begin
                    if (k > 0) @(negedge clk);
                    host_wr_vld  = 1'b1;
                    host_wr_data = wpat(burst, k);
                end
                if (conflict) begin
                    for (int k = 0; k < BEATS; k++) begin
                        @(negedge clk);
                        host_wr_data = wpat(burst + 1, k);
                    end
                end
                @(negedge clk);
                host_wr_vld = 1'b0;
            end
            begin
                for (int i = 0; i < NS; i++) begin
                    if (i > 0) @(negedge clk);
                    s_vld[i] = dev_wr_vld;
                    s_dat[i] = dev_wr_data;
                    s_clk[i] = dev_clk;
                    s_err[i] = host_wr_err;
                end
            end
        join
        first = -1;
        for (int i = NS - 1; i >= 0; i--) if (s_vld[i] === 1'b1) first = i;
        check(first == exp_first, "R5", "first device write beat cycle",
              64'(first), 64'(exp_first));
        if (first < 0 || first + 2 * BEATS >= NS) return;
        check(s_clk[first] === 1'b0 && s_clk[first+1] === 1'b1, "R4",
              "beat aligned to dev_clk fall", {s_clk[first], s_clk[first+1]}, 64'b01);
        for (int k = 0; k < BEATS; k++) begin
            check(s_vld[first+2*k] === 1'b1 && s_vld[first+2*k+1] === 1'b1 &&
                  s_dat[first+2*k] === wpat(burst, k) &&
                  s_dat[first+2*k+1] === wpat(burst, k), "R4",
                  "device write beat held two cycles", s_dat[first+2*k+1], wpat(burst, k));
        end
        check(s_vld[first+2*BEATS] === 1'b0, "R4", "valid drops after beat 7",
              64'(s_vld[first+2*BEATS]), 64'd0);
        if (conflict) begin
            check(s_err[8] === 1'b0 && s_err[9] === 1'b1 && s_err[16] === 1'b1, "R8",
                  "reject flags for second burst", {s_err[8], s_err[9], s_err[16]}, 64'b011);
        end else begin
            check(s_err[9] === 1'b0, "R8", "no reject without conflict", 64'(s_err[9]), 64'd0);
        end
    endtask

    task automatic run_rd(input int burst, input bit extra);
        @(negedge clk);
        while (dev_clk !== 1'b0) @(negedge clk);
        fork
            begin
                for (int k = 0; k < BEATS; k++) begin
                    if (k > 0) repeat (2) @(negedge clk);
                    dev_rd_vld  = 1'b1;
                    dev_rd_data = rpat(burst, k);
                end
                repeat (2) @(negedge clk);
                if (extra) begin
                    dev_rd_data = rpat(burst + 1, 0);
                    repeat (2) @(negedge clk);
                end
                dev_rd_vld = 1'b0;
            end
            begin
                for (int i = 0; i < NS; i++) begin
                    if (i > 0) @(negedge clk);
                    s_vld[i] = host_rd_vld;
                    s_dat[i] = host_rd_data;
                    s_err[i] = host_rd_err;
                end
            end
        join
        // last device beat captured at bus edge 15 -> last host beat at sample 18
        for (int j = 0; j < BEATS; j++) begin
            check(s_vld[11+j] === 1'b1 && s_dat[11+j] === rpat(burst, j), "R6",
                  "host read beat in order", s_dat[11+j], rpat(burst, j));
        end
        check(s_vld[10] === 1'b0 && s_vld[19] === 1'b0, "R7",
              "read window bounded", {s_vld[10], s_vld[19]}, 64'd0);
        if (extra) begin
            check(s_err[18] === 1'b1 && s_err[19] === 1'b0, "R9",
                  "read reject pulse", {s_err[18], s_err[19]}, 64'b10);
        end else begin
            check(s_err[18] === 1'b0, "R9", "no read reject", 64'(s_err[18]), 64'd0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL ALL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        host_cmd = 32'hFFFFFFFF;
        repeat (3) @(negedge clk);
        // R2 reset state
        check(dev_cmd === IDLE_WORD, "R2", "dev_cmd in reset", 64'(dev_cmd), 64'(IDLE_WORD));
        check(dev_clk === 1'b0 && dev_wr_vld === 1'b0 && host_rd_vld === 1'b0 &&
              host_wr_err === 1'b0 && host_rd_err === 1'b0, "R2", "outputs in reset",
              {dev_clk, dev_wr_vld, host_rd_vld, host_wr_err, host_rd_err}, 64'd0);
        rst_n = 1'b1;
        // R3 divider phase
        for (int i = 1; i <= 6; i++) begin
            @(negedge clk);
            check(dev_clk === ((i % DIV) >= DIV / 2), "R3", "dev_clk phase",
                  64'(dev_clk), 64'((i % DIV) >= DIV / 2));
        end
        // R1 command table
        for (int v = 0; v < 6; v++) begin
            host_cmd = CMD_VEC[v][63:32];
            @(negedge clk);
            check(dev_cmd === CMD_VEC[v][31:0], "R1", "command relay",
                  64'(dev_cmd), 64'(CMD_VEC[v][31:0]));
        end
        run_wr(1, 1'b0, 1'b0);
        run_wr(3, 1'b1, 1'b0);
        run_wr(5, 1'b0, 1'b1);
        run_wr(7, 1'b1, 1'b0);
        run_rd(1, 1'b0);
        run_rd(3, 1'b1);
        run_rd(5, 1'b0);
        // R2 reset in the middle of a write line
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            host_wr_vld  = 1'b1;
            host_wr_data = wpat(20, k);
        end
        @(negedge clk);
        host_wr_vld = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check(dev_wr_vld === 1'b0 && dev_cmd === IDLE_WORD, "R2", "mid-line reset",
              {dev_wr_vld, dev_cmd}, {1'b0, IDLE_WORD});
        rst_n = 1'b1;
        run_wr(9, 1'b0, 1'b0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule